// File: doc/BRIEF.md
# Context ID register access controller

This block owns the 64-bit process-identifier context register used at privilege level 1 and a companion context register used at level 2. Every system-register read or write whose selector hits one of the two encodings for the context register comes through here. The block resolves that access to exactly one outcome: a direct data access to one of the two registers, an undefined-instruction indication, a trap to level 2 with a syndrome class, or a request to redirect the access to memory at a fixed offset.

The outcome depends on the current privilege level and on a prioritized chain of hypervisor configuration conditions. These are a level-2 enable, virtual-memory trap bits, fine-grained trap controls, nested-virtualization bits and host mode. Two selector encodings, a primary one and an alias, reach the same level-1 storage under different rules. Only the low 32 bits of each register hold state, and the upper half always reads as zero. The outcome flags are combinational in the strobe cycle. Register writes land on the clock edge that samples the strobe.

Top module: `ctxid_access_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears both context registers to zero.
- R2: A matching access from privilege level 0 (`privLevel`=0) through either selector raises `undefFlag`.
- R3: At level 1 through the primary selector (`accSel`=16'hC681, packed as {op0[1:0],op1[2:0],CRn[3:0],CRm[3:0],op2[2:0]}), when `el2Enable` is set and `vmTrapRd` (read) or `vmTrapWr` (write) is set, `trapFlag` rises with `trapClass`=6'h18. This check has the highest priority at that level.
- R4: With no R3 trap, when `el2Enable` and `fgtImpl` are set, and either `hasEl3` is clear or `el3FgtEnable` is set, the level-1 primary access traps as in R3 if `fgtTrapRd` (read) or `fgtTrapWr` (write) is set.
- R5: With no R3 or R4 trap, a level-1 primary access with `nvBits`=3'b111 raises `memRedirect` with `memOffset`=12'h108.
- R6: A level-1 primary access that none of R3 to R5 catches is a data access (`dataAck`) to the level-1 register.
- R7: Through the primary selector, a level-2 access reaches the level-2 register when `hostMode` is set and the level-1 register when it is clear. A level-3 access always reaches the level-1 register.
- R8: At level 1 through the alias selector (`accSel`=16'hEE81, op1=3'b101), `nvBits`=3'b101 gives a memory redirect to 12'h108. Otherwise `nvBits[0]`=1 gives a trap with class 6'h18. Otherwise the access is undefined.
- R9: At levels 2 and 3 through the alias selector, `hostMode` set gives a data access to the level-1 register and `hostMode` clear gives undefined.
- R10: In the strobe cycle a matching access raises exactly one of `dataAck`, `undefFlag`, `trapFlag`, `memRedirect`. With no strobe, or with a selector matching neither encoding, none of them is raised. `trapClass` and `memOffset` are zero when their flag is low.
- R11: A data-access write stores `wrData[31:0]` into the selected register at the sampling edge, and bits 63:32 are kept zero. Undefined, trapped and redirected writes leave both registers unchanged.
- R12: `rdData` shows the selected register only for a data-access read and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| accValid | input | 1 | Access strobe, one cycle per access |
| accWrite | input | 1 | 1 = write, 0 = read |
| accSel | input | 16 | Encoded register selector {op0,op1,CRn,CRm,op2} |
| privLevel | input | 2 | Current privilege level 0 to 3 |
| el2Enable | input | 1 | Level 2 enabled |
| hasEl3 | input | 1 | Level 3 implemented |
| fgtImpl | input | 1 | Fine-grained trapping implemented |
| el3FgtEnable | input | 1 | Level-3 enable for fine-grained traps |
| vmTrapRd | input | 1 | Virtual-memory read trap bit |
| vmTrapWr | input | 1 | Virtual-memory write trap bit |
| fgtTrapRd | input | 1 | Per-register fine-grained read trap bit |
| fgtTrapWr | input | 1 | Per-register fine-grained write trap bit |
| nvBits | input | 3 | Nested-virtualization control bits |
| hostMode | input | 1 | Level 2 runs as host |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Read data, zero unless data read |
| dataAck | output | 1 | Outcome: data access |
| undefFlag | output | 1 | Outcome: undefined instruction |
| trapFlag | output | 1 | Outcome: trap to level 2 |
| trapClass | output | 6 | Syndrome class, 6'h18 with trapFlag |
| memRedirect | output | 1 | Outcome: redirect to memory |
| memOffset | output | 12 | Memory offset, 12'h108 with memRedirect |

## Verification
The outcome flags, `trapClass`, `memOffset` and `rdData` are combinational and belong to the cycle in which the strobe is high. The bench drives each access just after a falling edge and samples these outputs two nanoseconds later, before the next rising edge. A write becomes visible on the rising edge that samples its strobe. The bench therefore confirms stored state with a separate read access in a later cycle, and uses the same method to show that non-data writes left both registers untouched.

// File: rtl/ctxid_pkg.sv
package ctxid_pkg;

  typedef enum logic [2:0] {
    OUT_NONE  = 3'd0,
    OUT_DATA  = 3'd1,
    OUT_UNDEF = 3'd2,
    OUT_TRAP  = 3'd3,
    OUT_MEM   = 3'd4
  } outcome_e;

  typedef enum logic {
    TGT_EL1 = 1'b0,
    TGT_EL2 = 1'b1
  } target_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEl1;
    logic wrEl2;
    logic rdEl1;
    logic rdEl2;
  } ctrl_strb_t;

endpackage

// File: rtl/ctxid_decode.sv
module ctxid_decode
  import ctxid_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int EC_W = 6,
  parameter int OFS_W = 12,
  parameter logic [SEL_W-1:0] PRIM_SEL = 16'hC681,
  parameter logic [SEL_W-1:0] ALIAS_SEL = 16'hEE81,
  parameter logic [EC_W-1:0] TRAP_EC = 6'h18,
  parameter logic [OFS_W-1:0] MEM_OFS = 12'h108
) (
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [SEL_W-1:0] accSel,
  input  logic [1:0]       privLevel,
  input  logic             el2Enable,
  input  logic             hasEl3,
  input  logic             fgtImpl,
  input  logic             el3FgtEnable,
  input  logic             vmTrapRd,
  input  logic             vmTrapWr,
  input  logic             fgtTrapRd,
  input  logic             fgtTrapWr,
  input  logic [2:0]       nvBits,
  input  logic             hostMode,
  output ctrl_strb_t       strb,
  output logic             dataAck,
  output logic             undefFlag,
  output logic             trapFlag,
  output logic [EC_W-1:0]  trapClass,
  output logic             memRedirect,
  output logic [OFS_W-1:0] memOffset
);

  localparam logic [2:0] NV_PRIM_MEM  = 3'b111;
  localparam logic [2:0] NV_ALIAS_MEM = 3'b101;

  logic primHit, aliasHit;
  logic vmTrapHit, fgtTrapHit, fgtAllowed;
  outcome_e outcome;
  target_e  target;

  assign primHit  = accValid && (accSel == PRIM_SEL);
  assign aliasHit = accValid && (accSel == ALIAS_SEL);

  assign vmTrapHit  = el2Enable && (accWrite ? vmTrapWr : vmTrapRd);
  assign fgtAllowed = el2Enable && fgtImpl && (!hasEl3 || el3FgtEnable);
  assign fgtTrapHit = fgtAllowed && (accWrite ? fgtTrapWr : fgtTrapRd);

  always_comb begin
    outcome = OUT_NONE;
    target  = TGT_EL1;
    if (primHit || aliasHit) begin
      if (privLevel == 2'd0) begin
        outcome = OUT_UNDEF;
      end else if (primHit) begin
        unique case (privLevel)
          2'd1: begin
            if (vmTrapHit)                outcome = OUT_TRAP;
            else if (fgtTrapHit)          outcome = OUT_TRAP;
            else if (nvBits == NV_PRIM_MEM) outcome = OUT_MEM;
            else                          outcome = OUT_DATA;
          end
          2'd2: begin
            outcome = OUT_DATA;
            target  = hostMode ? TGT_EL2 : TGT_EL1;
          end
          default: outcome = OUT_DATA;
        endcase
      end else begin
        if (privLevel == 2'd1) begin
          if (nvBits == NV_ALIAS_MEM) outcome = OUT_MEM;
          else if (nvBits[0])         outcome = OUT_TRAP;
          else                        outcome = OUT_UNDEF;
        end else begin
          outcome = hostMode ? OUT_DATA : OUT_UNDEF;
        end
      end
    end
  end

  assign dataAck     = (outcome == OUT_DATA);
  assign undefFlag   = (outcome == OUT_UNDEF);
  assign trapFlag    = (outcome == OUT_TRAP);
  assign memRedirect = (outcome == OUT_MEM);
  assign trapClass   = trapFlag ? TRAP_EC : '0;
  assign memOffset   = memRedirect ? MEM_OFS : '0;

  assign strb.wrEl1 = dataAck &&  accWrite && (target == TGT_EL1);
  assign strb.wrEl2 = dataAck &&  accWrite && (target == TGT_EL2);
  assign strb.rdEl1 = dataAck && !accWrite && (target == TGT_EL1);
  assign strb.rdEl2 = dataAck && !accWrite && (target == TGT_EL2);

endmodule

// File: rtl/ctxid_regs.sv
module ctxid_regs
  import ctxid_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ID_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_strb_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int NUM_CTX = 2;
  localparam int PAD_W = DATA_W - ID_W;

  logic [ID_W-1:0] ctxQ [NUM_CTX];
  logic [NUM_CTX-1:0] wrEn;
  logic [NUM_CTX-1:0] rdEn;

  assign wrEn = {strb.wrEl2, strb.wrEl1};
  assign rdEn = {strb.rdEl2, strb.rdEl1};

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
    always_ff @(posedge clk) begin
      if (rst)          ctxQ[i] <= '0;
      else if (wrEn[i]) ctxQ[i] <= wrData[ID_W-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (rdEn[i]) rdData = {{PAD_W{1'b0}}, ctxQ[i]};
    end
  end

endmodule

// File: rtl/ctxid_access_ctrl.sv
module ctxid_access_ctrl
  import ctxid_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ID_W = 32,
  parameter int SEL_W = 16,
  parameter int EC_W = 6,
  parameter int OFS_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [SEL_W-1:0]  accSel,
  input  logic [1:0]        privLevel,
  input  logic              el2Enable,
  input  logic              hasEl3,
  input  logic              fgtImpl,
  input  logic              el3FgtEnable,
  input  logic              vmTrapRd,
  input  logic              vmTrapWr,
  input  logic              fgtTrapRd,
  input  logic              fgtTrapWr,
  input  logic [2:0]        nvBits,
  input  logic              hostMode,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              dataAck,
  output logic              undefFlag,
  output logic              trapFlag,
  output logic [EC_W-1:0]   trapClass,
  output logic              memRedirect,
  output logic [OFS_W-1:0]  memOffset
);

  ctrl_strb_t strb;

  ctxid_decode #(
    .SEL_W(SEL_W), .EC_W(EC_W), .OFS_W(OFS_W)
  ) u_ctl (
    .accValid(accValid), .accWrite(accWrite), .accSel(accSel),
    .privLevel(privLevel), .el2Enable(el2Enable), .hasEl3(hasEl3),
    .fgtImpl(fgtImpl), .el3FgtEnable(el3FgtEnable),
    .vmTrapRd(vmTrapRd), .vmTrapWr(vmTrapWr),
    .fgtTrapRd(fgtTrapRd), .fgtTrapWr(fgtTrapWr),
    .nvBits(nvBits), .hostMode(hostMode),
    .strb(strb), .dataAck(dataAck), .undefFlag(undefFlag),
    .trapFlag(trapFlag), .trapClass(trapClass),
    .memRedirect(memRedirect), .memOffset(memOffset)
  );

  ctxid_regs #(
    .DATA_W(DATA_W), .ID_W(ID_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/ctxid_checker.sv
module ctxid_checker #(
  parameter int DATA_W = 64,
  parameter int SEL_W = 16,
  parameter int EC_W = 6,
  parameter int OFS_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              accValid,
  input logic              accWrite,
  input logic [SEL_W-1:0]  accSel,
  input logic [1:0]        privLevel,
  input logic              hostMode,
  input logic [DATA_W-1:0] rdData,
  input logic              dataAck,
  input logic              undefFlag,
  input logic              trapFlag,
  input logic [EC_W-1:0]   trapClass,
  input logic              memRedirect,
  input logic [OFS_W-1:0]  memOffset
);

  logic selKnown;
  assign selKnown = (accSel == 16'hC681) || (accSel == 16'hEE81);

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    (accValid && selKnown) |-> ($countones({dataAck, undefFlag, trapFlag, memRedirect}) == 1));

  assert_silent_R10: assert property (@(posedge clk) disable iff (rst)
    !(accValid && selKnown) |-> !(dataAck || undefFlag || trapFlag || memRedirect));

  assert_el0_undef_R2: assert property (@(posedge clk) disable iff (rst)
    (accValid && selKnown && privLevel == 2'd0) |-> undefFlag);

  assert_trap_class_R3: assert property (@(posedge clk) disable iff (rst)
    trapFlag |-> (trapClass == 6'h18));

  assert_mem_offset_R5: assert property (@(posedge clk) disable iff (rst)
    memRedirect |-> (memOffset == 12'h108));

  assert_el3_prim_data_R7: assert property (@(posedge clk) disable iff (rst)
    (accValid && accSel == 16'hC681 && privLevel == 2'd3) |-> dataAck);

  assert_alias_host_R9: assert property (@(posedge clk) disable iff (rst)
    (accValid && accSel == 16'hEE81 && privLevel[1]) |-> (hostMode ? dataAck : undefFlag));

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (rst)
    rdData[63:32] == 32'h0);

  assert_rd_gated_R12: assert property (@(posedge clk) disable iff (rst)
    !(dataAck && !accWrite) |-> (rdData == '0));

endmodule

bind ctxid_access_ctrl ctxid_checker u_chk (.*);

// File: tb/sim_ctxid_access_ctrl.sv
module sim_ctxid_access_ctrl;

  localparam logic [15:0] PRIM = 16'hC681;
  localparam logic [15:0] ALIAS = 16'hEE81;
  localparam logic [63:0] EL1V = 64'h0000_0000_1111_2222;
  localparam logic [63:0] EL2V = 64'h0000_0000_3333_4444;

  // expected outcome codes: 0 none,1 data,2 undef,3 trap,4 mem
  typedef struct packed {
    logic       useAlias;
    logic [1:0] priv;
    logic       en2;
    logic       el3;
    logic       fgtI;
    logic       fgtE;
    logic       trvm;
    logic       fgtR;
    logic [2:0] nv;
    logic       host;
    logic [2:0] exp;
    logic       tgt2;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,3'd2,1'b0}, // R2
    '{1'b1,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b101,1'b1,3'd2,1'b0}, // R2
    '{1'b0,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'b000,1'b0,3'd3,1'b0}, // R3
    '{1'b0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,3'b111,1'b0,3'd4,1'b0}, // R3 off
    '{1'b0,2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,3'b000,1'b0,3'd3,1'b0}, // R4
    '{1'b0,2'd1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,3'b000,1'b0,3'd1,1'b0}, // R4 gated
    '{1'b0,2'd1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,3'b000,1'b0,3'd3,1'b0}, // R4
    '{1'b0,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,3'b000,1'b0,3'd1,1'b0}, // R4 no impl
    '{1'b0,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'b111,1'b0,3'd3,1'b0}, // R3 prio
    '{1'b0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b111,1'b0,3'd4,1'b0}, // R5
    '{1'b0,2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b101,1'b0,3'd1,1'b0}, // R6
    '{1'b0,2'd2,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'b111,1'b1,3'd1,1'b1}, // R7
    '{1'b0,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,3'd1,1'b0}, // R7
    '{1'b0,2'd3,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,3'b111,1'b1,3'd1,1'b0}, // R7
    '{1'b1,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b101,1'b0,3'd4,1'b0}, // R8
    '{1'b1,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b111,1'b0,3'd3,1'b0}, // R8
    '{1'b1,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b001,1'b0,3'd3,1'b0}, // R8
    '{1'b1,2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b100,1'b0,3'd2,1'b0}, // R8
    '{1'b1,2'd1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'b000,1'b1,3'd2,1'b0}, // R8
    '{1'b1,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,3'd1,1'b0}, // R9
    '{1'b1,2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,3'd2,1'b0}, // R9
    '{1'b1,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b1,3'd1,1'b0}, // R9
    '{1'b1,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'b000,1'b0,3'd2,1'b0}  // R9
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic accValid = 1'b0, accWrite = 1'b0;
  logic [15:0] accSel = '0;
  logic [1:0] privLevel = '0;
  logic el2Enable = 0, hasEl3 = 0, fgtImpl = 0, el3FgtEnable = 0;
  logic vmTrapRd = 0, vmTrapWr = 0, fgtTrapRd = 0, fgtTrapWr = 0;
  logic [2:0] nvBits = '0;
  logic hostMode = 0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic dataAck, undefFlag, trapFlag, memRedirect;
  logic [5:0] trapClass;
  logic [11:0] memOffset;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ctxid_access_ctrl u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] codeVec(logic [2:0] c);
    case (c)
      3'd1: return 4'b1000;
      3'd2: return 4'b0100;
      3'd3: return 4'b0010;
      3'd4: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic clearCfg();
    el2Enable = 0; hasEl3 = 0; fgtImpl = 0; el3FgtEnable = 0;
    vmTrapRd = 0; vmTrapWr = 0; fgtTrapRd = 0; fgtTrapWr = 0;
    nvBits = 3'b000; hostMode = 0;
  endtask

  // drive one access after a falling edge; outputs valid 2 ns later
  task automatic startAcc(logic wr, logic [15:0] sel, logic [1:0] pl, logic [63:0] d);
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; accSel = sel; privLevel = pl; wrData = d;
    #2;
  endtask

  task automatic endAcc();
    @(posedge clk);
    #1;
    accValid = 1'b0; accWrite = 1'b0; wrData = '0;
  endtask

  task automatic readReg(string req, logic tgt2, logic [63:0] exp);
    clearCfg();
    hostMode = tgt2;
    startAcc(1'b0, PRIM, tgt2 ? 2'd2 : 2'd3, '0);
    chk(req, rdData, exp);
    endAcc();
  endtask

  task automatic outc(string req, logic [2:0] expCode);
    chk(req, {60'd0, dataAck, undefFlag, trapFlag, memRedirect}, {60'd0, codeVec(expCode)});
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    readReg("R1 el1 after reset", 1'b0, 64'd0);
    readReg("R1 el2 after reset", 1'b1, 64'd0);

    // R11 load both registers, upper bits dropped
    clearCfg();
    startAcc(1'b1, PRIM, 2'd3, 64'hDEAD_BEEF_1111_2222);
    outc("R11 el3 write data", 3'd1);
    endAcc();
    hostMode = 1'b1;
    startAcc(1'b1, PRIM, 2'd2, 64'hFFFF_0000_3333_4444);
    endAcc();
    readReg("R11 el1 stored", 1'b0, EL1V);
    readReg("R11 el2 stored", 1'b1, EL2V);

    // vector table (reads only)
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      el2Enable = v.en2; hasEl3 = v.el3; fgtImpl = v.fgtI; el3FgtEnable = v.fgtE;
      vmTrapRd = v.trvm; vmTrapWr = 0; fgtTrapRd = v.fgtR; fgtTrapWr = 0;
      nvBits = v.nv; hostMode = v.host;
      startAcc(1'b0, v.useAlias ? ALIAS : PRIM, v.priv, '0);
      outc($sformatf("R10 vec%0d outcome", i), v.exp);
      chk($sformatf("R12 vec%0d rdData", i), rdData,
          (v.exp == 3'd1) ? (v.tgt2 ? EL2V : EL1V) : 64'd0);
      chk($sformatf("R3 vec%0d trapClass", i), {58'd0, trapClass},
          (v.exp == 3'd3) ? 64'h18 : 64'd0);
      chk($sformatf("R5 vec%0d memOffset", i), {52'd0, memOffset},
          (v.exp == 3'd4) ? 64'h108 : 64'd0);
      endAcc();
    end

    // R3 write trap uses write bit only
    clearCfg(); el2Enable = 1; vmTrapWr = 1;
    startAcc(1'b1, PRIM, 2'd1, 64'h0000_0000_AAAA_0001);
    outc("R3 write vm trap", 3'd3);
    endAcc();
    clearCfg(); el2Enable = 1; vmTrapRd = 1;
    startAcc(1'b1, PRIM, 2'd1, 64'h0000_0000_5555_0001);
    outc("R6 write ignores read trap bit", 3'd1);
    endAcc();
    readReg("R6 el1 written at el1", 1'b0, 64'h0000_0000_5555_0001);

    // R4 write fine-grained trap, R11 no change
    clearCfg(); el2Enable = 1; fgtImpl = 1; fgtTrapWr = 1;
    startAcc(1'b1, PRIM, 2'd1, 64'h0000_0000_AAAA_0002);
    outc("R4 write fgt trap", 3'd3);
    endAcc();
    // R5 write redirect
    clearCfg(); nvBits = 3'b111;
    startAcc(1'b1, PRIM, 2'd1, 64'h0000_0000_AAAA_0003);
    outc("R5 write redirect", 3'd4);
    endAcc();
    // R2 write undefined
    clearCfg();
    startAcc(1'b1, ALIAS, 2'd0, 64'h0000_0000_AAAA_0004);
    outc("R2 el0 write", 3'd2);
    endAcc();
    readReg("R11 el1 unchanged after blocked writes", 1'b0, 64'h0000_0000_5555_0001);
    readReg("R11 el2 unchanged after blocked writes", 1'b1, EL2V);

    // R9 alias write from el2 host targets el1
    clearCfg(); hostMode = 1;
    startAcc(1'b1, ALIAS, 2'd2, 64'h1234_5678_9ABC_DEF0);
    endAcc();
    readReg("R9 alias host write el1", 1'b0, 64'h0000_0000_9ABC_DEF0);
    readReg("R9 alias host write el2 kept", 1'b1, EL2V);

    // R10 unmatched selector and no strobe
    clearCfg();
    startAcc(1'b0, 16'hC682, 2'd0, '0);
    outc("R10 unmatched selector", 3'd0);
    chk("R12 unmatched rdData", rdData, 64'd0);
    endAcc();
    @(negedge clk);
    accSel = PRIM; privLevel = 2'd0;
    #2;
    outc("R10 no strobe", 3'd0);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    readReg("R1 el1 after second reset", 1'b0, 64'd0);
    readReg("R1 el2 after second reset", 1'b1, 64'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule